// File: doc/BRIEF.md
# Vector Lane Scalar Transfer Unit

This unit moves a single element between a 64-bit vector register and a 32-bit general-purpose value. An element is a byte, a halfword or a word. An extract pulls the element out of a vector register and widens it to 32 bits, with either zero fill or sign fill. An insert writes the low bits of the general value into one element slot and leaves the rest of the register unchanged.

A broadcast copies the low bits of the general value into every element of a 64-bit target, or into a 128-bit target made of two neighbouring registers. The element position is found by shifting the element index left by the size code. That gives a byte offset inside the 64-bit register:
- offset bit 2 picks the 32-bit half;
- the two low offset bits, times eight, give the bit position inside that half.

The vector register file is held inside the unit. A side read port exposes any register combinationally. Each operation is offered for one cycle with `op_valid`. Encodings that are not allowed raise a one-cycle `fault` and leave all state untouched. Build options decide whether sub-word elements, broadcasts and the upper half of the register bank exist.

Top module: `vlane_xfer`

## Requirements
- R1: Operation codes are `op_kind` 00 extract, 01 insert, 10 broadcast and 11 reserved. The byte offset is `(lane_sel << elem_size)` truncated to 3 bits, with `elem_size` 0 byte, 1 halfword, 2 word and 3 reserved. Offset bit 2 set selects bits 63:32 of the register and clear selects bits 31:0. Offset bits 1:0 times 8 give the bit position in that half.
- R2: A byte extract returns the 8 bits at the computed position. `zero_ext`=1 fills bits 31:8 with zeros and `zero_ext`=0 fills them with copies of bit 7.
- R3: A halfword extract returns the 16 bits at position 0 or 16. Bits 31:16 are filled with zeros when `zero_ext`=1 and with copies of bit 15 otherwise.
- R4: A word extract or insert moves all 32 bits of the selected half, with no extension.
- R5: A byte or halfword insert replaces only the 8 or 16 bits at the computed position. The other bits of the 64-bit register keep their values.
- R6: When HAS_SIMD=0, any extract or insert with `elem_size` 0 or 1 faults, and every broadcast faults.
- R7: When HAS_HIGH_BANK=0, a register index with its top bit (bit 4 at the default width) set faults. An extract or insert with `elem_size`=3 always faults. When HAS_HIGH_BANK=1, the upper registers are reachable.
- R8: A broadcast with `bc_byte`=1 repeats `gpr_in[7:0]` into each byte. `bc_half`=1 repeats `gpr_in[15:0]` into each halfword. With both flags clear, `gpr_in` is repeated into both words.
- R9: A broadcast with `bc_byte` and `bc_half` both set faults. A broadcast with `bc_wide`=1 and an odd register index also faults.
- R10: A broadcast with `bc_wide`=1 writes the same pattern into the even register given and the odd register after it.
- R11: An accepted extract raises `gpr_valid` and updates `gpr_out` on the clock edge that takes the operation. A faulting operation raises `fault` on that same edge instead, keeps `gpr_valid` low and changes no register. Operation code 11 always faults.
- R12: Reset clears every vector register and drives `gpr_out`, `gpr_valid` and `fault` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation presented this cycle |
| op_kind | input | 2 | 00 extract, 01 insert, 10 broadcast, 11 reserved |
| vreg_sel | input | REG_AW | Vector register index |
| lane_sel | input | 3 | Element index |
| elem_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| zero_ext | input | 1 | Extract widening: 1 zero fill, 0 sign fill |
| bc_byte | input | 1 | Broadcast 8-bit elements |
| bc_half | input | 1 | Broadcast 16-bit elements |
| bc_wide | input | 1 | Broadcast to a 128-bit register pair |
| gpr_in | input | 32 | General-purpose source value |
| gpr_out | output | 32 | Extract result, held until the next extract |
| gpr_valid | output | 1 | One-cycle pulse when a new extract result is present |
| fault | output | 1 | One-cycle pulse for a rejected operation |
| peek_sel | input | REG_AW | Side read port register index |
| peek_data | output | 64 | Contents of register `peek_sel` |

## Verification
A wrong offset or half selection shows up in `gpr_out` on the cycle after the extract. After an insert, it shows up on `peek_data` as a changed byte outside the target slot. A merge mask that is too wide or misaligned corrupts neighbouring bits that later extracts or peeks expose. A legality decode that lets a bad encoding through leaves `fault` low and visibly rewrites the target register on `peek_data` in the very next cycle. The second register of a 128-bit broadcast is read back directly, so a missing pair write is caught at once.

// File: rtl/vlane_xfer.sv
module vlane_xfer #(
  parameter int REG_AW        = 5,
  parameter bit HAS_SIMD      = 1'b1,
  parameter bit HAS_HIGH_BANK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic [REG_AW-1:0] vreg_sel,
  input  logic [2:0]        lane_sel,
  input  logic [1:0]        elem_size,
  input  logic              zero_ext,
  input  logic              bc_byte,
  input  logic              bc_half,
  input  logic              bc_wide,
  input  logic [31:0]       gpr_in,
  output logic [31:0]       gpr_out,
  output logic              gpr_valid,
  output logic              fault,
  input  logic [REG_AW-1:0] peek_sel,
  output logic [63:0]       peek_data
);
  localparam int NREGS = 1 << REG_AW;
  localparam logic [1:0] K_EXT = 2'b00, K_INS = 2'b01, K_BC = 2'b10;

  logic [63:0] vregs [NREGS];

  logic [2:0]  offset;
  logic [4:0]  bitpos;
  logic [63:0] cur;
  logic [31:0] word, shifted, ext_val, ins_word, fmask;
  logic [63:0] new_reg, pattern;
  logic        bank_bad, illegal;

  assign offset   = lane_sel << elem_size;
  assign bitpos   = {offset[1:0], 3'b000};
  assign cur      = vregs[vreg_sel];
  assign word     = offset[2] ? cur[63:32] : cur[31:0];
  assign shifted  = word >> bitpos;
  assign bank_bad = !HAS_HIGH_BANK && vreg_sel[REG_AW-1];

  always_comb begin
    case (elem_size)
      2'd0:    ext_val = zero_ext ? {24'd0, shifted[7:0]}  : {{24{shifted[7]}},  shifted[7:0]};
      2'd1:    ext_val = zero_ext ? {16'd0, shifted[15:0]} : {{16{shifted[15]}}, shifted[15:0]};
      default: ext_val = word;
    endcase
  end

  always_comb begin
    case (elem_size)
      2'd0:    fmask = 32'h0000_00FF << bitpos;
      2'd1:    fmask = 32'h0000_FFFF << bitpos;
      default: fmask = 32'hFFFF_FFFF;
    endcase
  end

  assign ins_word = (word & ~fmask) | ((gpr_in << bitpos) & fmask);
  assign new_reg  = offset[2] ? {ins_word, cur[31:0]} : {cur[63:32], ins_word};
  assign pattern  = bc_byte ? {8{gpr_in[7:0]}} : bc_half ? {4{gpr_in[15:0]}} : {2{gpr_in}};

  always_comb begin
    case (op_kind)
      K_EXT, K_INS: illegal = bank_bad || (elem_size == 2'd3) || (elem_size != 2'd2 && !HAS_SIMD);
      K_BC:         illegal = !HAS_SIMD || bank_bad || (bc_byte && bc_half) || (bc_wide && vreg_sel[0]);
      default:      illegal = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) vregs[i] <= '0;
    end else if (op_valid && !illegal) begin
      if (op_kind == K_INS) vregs[vreg_sel] <= new_reg;
      if (op_kind == K_BC) begin
        vregs[vreg_sel] <= pattern;
        if (bc_wide) vregs[{vreg_sel[REG_AW-1:1], 1'b1}] <= pattern;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpr_out   <= '0;
      gpr_valid <= 1'b0;
      fault     <= 1'b0;
    end else begin
      fault     <= op_valid && illegal;
      gpr_valid <= op_valid && !illegal && op_kind == K_EXT;
      if (op_valid && !illegal && op_kind == K_EXT) gpr_out <= ext_val;
    end
  end

  assign peek_data = vregs[peek_sel];

  assert_result_xor_fault_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({gpr_valid, fault}));

  assert_valid_only_after_extract_R11: assert property (@(posedge clk) disable iff (!rst_n)
    gpr_valid |-> ($past(op_valid) && $past(op_kind) == K_EXT));

  assert_fault_needs_op_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> $past(op_valid));

  assert_reserved_kind_faults_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == 2'b11) |=> fault);

  assert_byte_zero_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (gpr_valid && $past(elem_size) == 2'd0 && $past(zero_ext)) |-> gpr_out[31:8] == 24'd0);

  assert_half_sign_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (gpr_valid && $past(elem_size) == 2'd1 && !$past(zero_ext)) |-> gpr_out[31:16] == {16{gpr_out[15]}});

  assert_subword_needs_simd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !HAS_SIMD && op_kind == K_EXT && elem_size != 2'd2) |=> fault);

  assert_both_bc_flags_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_kind == K_BC && bc_byte && bc_half) |=> fault);
endmodule

// File: tb/vlane_xfer_tb.sv
`timescale 1ns/1ps
module vlane_xfer_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n, op_valid, zero_ext, bc_byte, bc_half, bc_wide;
  logic [1:0]  op_kind, elem_size;
  logic [4:0]  vreg_sel, peek_sel;
  logic [2:0]  lane_sel;
  logic [31:0] gpr_in, gpr_out, ns_gpr_out;
  logic        gpr_valid, fault, ns_gpr_valid, ns_fault;
  logic [63:0] peek_data, ns_peek_data;

  vlane_xfer u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .vreg_sel(vreg_sel),
    .lane_sel(lane_sel), .elem_size(elem_size), .zero_ext(zero_ext), .bc_byte(bc_byte),
    .bc_half(bc_half), .bc_wide(bc_wide), .gpr_in(gpr_in), .gpr_out(gpr_out),
    .gpr_valid(gpr_valid), .fault(fault), .peek_sel(peek_sel), .peek_data(peek_data));

  vlane_xfer #(.HAS_SIMD(1'b0), .HAS_HIGH_BANK(1'b1)) u_nosimd (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .vreg_sel(vreg_sel),
    .lane_sel(lane_sel), .elem_size(elem_size), .zero_ext(zero_ext), .bc_byte(bc_byte),
    .bc_half(bc_half), .bc_wide(bc_wide), .gpr_in(gpr_in), .gpr_out(ns_gpr_out),
    .gpr_valid(ns_gpr_valid), .fault(ns_fault), .peek_sel(peek_sel), .peek_data(ns_peek_data));

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  typedef struct packed {
    logic [1:0]  kind;
    logic [4:0]  vreg;
    logic [2:0]  lane;
    logic [1:0]  size;
    logic        uns, byt, hlf, wid;
    logic [31:0] gpr;
    logic        efault, evalid;
    logic [31:0] eout;
    logic [4:0]  pk;
    logic [63:0] epk;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 5'd2, 3'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h8899_AABB, 1'b0, 1'b0, 32'h0,         5'd2, 64'h0000_0000_8899_AABB}, // R4 word insert
    '{2'd1, 5'd2, 3'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1122_F344, 1'b0, 1'b0, 32'h0,         5'd2, 64'h1122_F344_8899_AABB}, // R1 upper half
    '{2'd0, 5'd2, 3'd5, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 1'b1, 32'hFFFF_FFF3, 5'd2, 64'h1122_F344_8899_AABB}, // R2 signed byte
    '{2'd0, 5'd2, 3'd5, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 1'b1, 32'h0000_00F3, 5'd2, 64'h1122_F344_8899_AABB}, // R2 unsigned byte
    '{2'd0, 5'd2, 3'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 1'b1, 32'hFFFF_8899, 5'd2, 64'h1122_F344_8899_AABB}, // R3 signed half at 16
    '{2'd0, 5'd2, 3'd2, 2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 1'b1, 32'h0000_F344, 5'd2, 64'h1122_F344_8899_AABB}, // R3 unsigned half upper
    '{2'd0, 5'd2, 3'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 1'b1, 32'h8899_AABB, 5'd2, 64'h1122_F344_8899_AABB}, // R4 word extract
    '{2'd1, 5'd2, 3'd3, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hDEAD_BE55, 1'b0, 1'b0, 32'h0,         5'd2, 64'h1122_F344_5599_AABB}, // R5 byte merge
    '{2'd1, 5'd2, 3'd3, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_7766, 1'b0, 1'b0, 32'h0,         5'd2, 64'h7766_F344_5599_AABB}, // R5 half merge
    '{2'd0, 5'd2, 3'd7, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, 1'b1, 32'h7766_F344, 5'd2, 64'h7766_F344_5599_AABB}, // R1 truncated offset
    '{2'd1, 5'd16,3'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1234_5678, 1'b1, 1'b0, 32'h0,         5'd16,64'h0},                    // R7 high bank
    '{2'd0, 5'd2, 3'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         1'b1, 1'b0, 32'h0,         5'd2, 64'h7766_F344_5599_AABB}, // R7 size 3
    '{2'd2, 5'd4, 3'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h1234_56AB, 1'b0, 1'b0, 32'h0,         5'd4, 64'hABAB_ABAB_ABAB_ABAB}, // R8 byte bcast
    '{2'd2, 5'd6, 3'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 32'hFFFF_C3D2, 1'b0, 1'b0, 32'h0,         5'd7, 64'hC3D2_C3D2_C3D2_C3D2}, // R10 pair
    '{2'd2, 5'd8, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'hCAFE_F00D, 1'b0, 1'b0, 32'h0,         5'd8, 64'hCAFE_F00D_CAFE_F00D}, // R8 word bcast
    '{2'd2, 5'd4, 3'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0000_0011, 1'b1, 1'b0, 32'h0,         5'd4, 64'hABAB_ABAB_ABAB_ABAB}, // R9 both flags
    '{2'd2, 5'd5, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0000_0022, 1'b1, 1'b0, 32'h0,         5'd5, 64'h0},                    // R9 odd pair
    '{2'd3, 5'd2, 3'd0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1, 1'b0, 32'h0,         5'd2, 64'h7766_F344_5599_AABB}  // R11 reserved
  };

  task automatic issue(input vec_t v);
    @(negedge clk);
    op_valid = 1'b1; op_kind = v.kind; vreg_sel = v.vreg; lane_sel = v.lane; elem_size = v.size;
    zero_ext = v.uns; bc_byte = v.byt; bc_half = v.hlf; bc_wide = v.wid; gpr_in = v.gpr;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_kind = '0; vreg_sel = '0; lane_sel = '0; elem_size = '0;
    zero_ext = 1'b0; bc_byte = 1'b0; bc_half = 1'b0; bc_wide = 1'b0; gpr_in = '0; peek_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 gpr_out", {32'd0, gpr_out}, 64'd0);
    chk("R12 flags", {62'd0, gpr_valid, fault}, 64'd0);
    for (int r = 0; r < 32; r += 7) begin
      peek_sel = 5'(r);
      #1 chk("R12 reg clear", peek_data, 64'd0);
    end

    for (int i = 0; i < NV; i++) begin
      issue(TBL[i]);
      peek_sel = TBL[i].pk;
      #1;
      chk($sformatf("row %0d fault", i), {63'd0, fault}, {63'd0, TBL[i].efault});
      chk($sformatf("row %0d valid", i), {63'd0, gpr_valid}, {63'd0, TBL[i].evalid});
      if (TBL[i].evalid) chk($sformatf("row %0d data", i), {32'd0, gpr_out}, {32'd0, TBL[i].eout});
      chk($sformatf("row %0d reg", i), peek_data, TBL[i].epk);
    end

    peek_sel = 5'd6;
    #1 chk("R10 even half of pair", peek_data, 64'hC3D2_C3D2_C3D2_C3D2);

    issue('{2'd0, 5'd2, 3'd1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 5'd0, 64'h0});
    #1 chk("R6 byte extract without SIMD", {63'd0, ns_fault}, 64'd1);
    chk("R6 no result without SIMD", {63'd0, ns_gpr_valid}, 64'd0);

    issue('{2'd2, 5'd4, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h5555_5555, 1'b0, 1'b0, 32'h0, 5'd0, 64'h0});
    peek_sel = 5'd4;
    #1 chk("R6 broadcast without SIMD", {63'd0, ns_fault}, 64'd1);
    chk("R6 register untouched", ns_peek_data, 64'd0);

    issue('{2'd1, 5'd20, 3'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0BAD_C0DE, 1'b0, 1'b0, 32'h0, 5'd0, 64'h0});
    peek_sel = 5'd20;
    #1 chk("R7 high bank allowed", {63'd0, ns_fault}, 64'd0);
    chk("R7 high bank written", ns_peek_data, 64'h0BAD_C0DE_0000_0000);
    chk("R7 high bank rejected on default", {63'd0, fault}, 64'd1);

    issue('{2'd0, 5'd20, 3'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0, 32'h0, 5'd0, 64'h0});
    #1 chk("R4 word extract without SIMD", {32'd0, ns_gpr_out}, 64'h0000_0000_0BAD_C0DE);

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    peek_sel = 5'd2;
    #1 chk("R12 reset clears register", peek_data, 64'd0);
    chk("R12 reset clears output", {32'd0, gpr_out}, 64'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule